// File: doc/BRIEF.md
# Four-Channel DMA Controller Programming Port

This block is the host side of a four-channel legacy-style DMA controller. It sits on an 8-bit I/O bus with a 16-location address space. Through it, software programs each channel's 16-bit base address and base count, its 6-bit mode, the channel mask bits, a command byte and software request bits. It also reads back the status byte and each channel's current address and current count. The transfer engine is outside the block. It receives the stored registers on dedicated outputs and returns its current address and count, terminal-count pulses and hardware request lines on dedicated inputs.

All registers are one byte wide on the bus. Each 16-bit value moves through a single port, low byte first and then high byte. A single byte-pointer bit, shared by all eight channel ports, chooses which half an access uses. Software must keep track of this pointer, or reset it by writing the clear-pointer location. Writes to the control locations set or clear individual mask bits, set all masks at once, clear all masks, select a channel's mode, and perform a master clear.

Top module: `dma_reg_port`

## Requirements
- R1: While rst_ni is low, and after it, mask_o is 4'hF, the byte pointer selects the low byte, and cmd_o, sw_req_o, status terminal-count bits, base registers and modes are all zero.
- R2: A write to offset 2n loads channel n's base address, and a write to offset 2n+1 loads its base count. The low byte is loaded when the pointer is low and the high byte when it is high. Every access (read or write) to offsets 0..7 toggles the one shared pointer. When wr_i and rd_i are both high, the access is a write and rdata_o is 8'h00.
- R3: A write to offset 0xC, whatever the data, returns the pointer to the low-byte state.
- R4: A read of offset 2n or 2n+1 returns the byte that the pointer selects from cur_addr_i or cur_cnt_i of channel n. rdata_o is 8'h00 whenever rd_i is low.
- R5: A write to offset 0xA sets mask bit data[1:0] to data[2]. The other mask bits keep their values.
- R6: A write to offset 0xF loads mask_o from data[3:0]. A write to offset 0xE, whatever the data, clears all four mask bits.
- R7: A write to offset 0xB stores data[7:2] as the mode of channel data[1:0] and drives it on mode_o[6n+5:6n]. Within that field, bits [1:0] are the transfer type, bit 2 is autoinitialize, bit 3 is decrement, and bits [5:4] are the operating mode.
- R8: A write to offset 0x8 stores the data byte on cmd_o.
- R9: A write to offset 0x9 sets software request bit data[1:0] on sw_req_o to data[2].
- R10: A read of offset 0x8 returns status. Bits [3:0] are terminal-count flags, set by tc_i pulses and held until a status read; the read clears them, but a tc_i pulse in the same cycle still sets its flag. Bits [7:4] are dreq_i OR sw_req_o.
- R11: A write to offset 0xD, whatever the data, performs a master clear with the effect of R1 on masks, pointer, command, requests and status flags. This takes priority over a same-cycle tc_i, and it keeps base registers and modes. A read of offset 0xD returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid in the cycle rd_i is high |
| cur_addr_i | input | 64 | Current address of each channel from the engine, channel n at [16n+15:16n] |
| cur_cnt_i | input | 64 | Current count of each channel from the engine |
| tc_i | input | 4 | Terminal-count pulse per channel |
| dreq_i | input | 4 | Hardware request per channel |
| base_addr_o | output | 64 | Base address of each channel |
| base_cnt_o | output | 64 | Base count of each channel |
| mode_o | output | 24 | Mode field of each channel, 6 bits per channel |
| mask_o | output | 4 | Channel mask bits, 1 = masked |
| cmd_o | output | 8 | Command byte |
| sw_req_o | output | 4 | Software request bits |

## Verification
A write takes effect at the rising edge that ends the cycle in which wr_i is high, so its effect on a register output is due one cycle later. Read data is combinational: it is due in the same cycle as rd_i and comes from the pointer and status state as they stood before that edge. The status flags cleared by a read, and the pointer toggled by an access, are therefore seen only from the next cycle on. The bench drives each access just after a falling edge and compares every output one time unit later against a behavioural model. It then advances the model to the state expected after the coming rising edge, so that each check lands in exactly the cycle in which its result is due.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;

  localparam logic [3:0] OFF_CMD      = 4'h8;  // write: command, read: status
  localparam logic [3:0] OFF_REQ      = 4'h9;
  localparam logic [3:0] OFF_MASK_ONE = 4'hA;
  localparam logic [3:0] OFF_MODE     = 4'hB;
  localparam logic [3:0] OFF_CLR_PTR  = 4'hC;
  localparam logic [3:0] OFF_MCLR     = 4'hD;  // write: master clear, read: zero
  localparam logic [3:0] OFF_UNMASK   = 4'hE;
  localparam logic [3:0] OFF_MASK_ALL = 4'hF;

  // stored mode field = wdata[7:2]
  typedef struct packed {
    logic [1:0] op_mode;
    logic       dec;
    logic       auto_init;
    logic [1:0] xfer;
  } chan_mode_t;

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clear_i,
  output logic hi_o
);

  logic hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_q <= 1'b0;
    else if (clear_i)  hi_q <= 1'b0;
    else if (toggle_i) hi_q <= ~hi_q;
  end

  assign hi_o = hi_q;

  a_r2_ptr_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_i && !clear_i |=> hi_o != $past(hi_o));

  a_r3_ptr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !hi_o);

  a_r2_ptr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !toggle_i && !clear_i |=> $stable(hi_o));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_addr_i,
  input  logic                  wr_cnt_i,
  input  logic                  wr_mode_i,
  input  logic                  hi_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  output logic [2*BYTE_W-1:0]   base_addr_o,
  output logic [2*BYTE_W-1:0]   base_cnt_o,
  output chan_mode_t            mode_o
);

  localparam int REG_W = 2 * BYTE_W;

  logic [REG_W-1:0] addr_q, cnt_q;
  chan_mode_t       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_addr_i) begin
        if (hi_i) addr_q[REG_W-1:BYTE_W] <= wdata_i;
        else      addr_q[BYTE_W-1:0]     <= wdata_i;
      end
      if (wr_cnt_i) begin
        if (hi_i) cnt_q[REG_W-1:BYTE_W] <= wdata_i;
        else      cnt_q[BYTE_W-1:0]     <= wdata_i;
      end
      if (wr_mode_i) mode_q <= chan_mode_t'(wdata_i[BYTE_W-1:2]);
    end
  end

  assign base_addr_o = addr_q;
  assign base_cnt_o  = cnt_q;
  assign mode_o      = mode_q;

  a_r2_lo_byte_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_i && !hi_i |=> base_addr_o[BYTE_W-1:0] == $past(wdata_i)
                        && $stable(base_addr_o[REG_W-1:BYTE_W]));

  a_r2_hi_byte_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i && hi_i |=> base_cnt_o[REG_W-1:BYTE_W] == $past(wdata_i)
                      && $stable(base_cnt_o[BYTE_W-1:0]));

  a_r7_mode_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode_i |=> $stable(mode_o));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  wr_cmd_i,
  input  logic                  wr_req_i,
  input  logic                  wr_mask_one_i,
  input  logic                  wr_unmask_i,
  input  logic                  wr_mask_all_i,
  input  logic                  mclr_i,
  input  logic                  stat_rd_i,
  input  logic [NUM_CH-1:0]     tc_i,
  input  logic [NUM_CH-1:0]     dreq_i,
  output logic [BYTE_W-1:0]     cmd_o,
  output logic [NUM_CH-1:0]     mask_o,
  output logic [NUM_CH-1:0]     sw_req_o,
  output logic [2*NUM_CH-1:0]   status_o
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SET_BIT = CH_W;

  logic [BYTE_W-1:0] cmd_q;
  logic [NUM_CH-1:0] mask_q, req_q, tc_q;
  logic [CH_W-1:0]   sel;

  assign sel = wdata_i[CH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
    end else if (mclr_i) begin
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
    end else begin
      if (wr_cmd_i)      cmd_q       <= wdata_i;
      if (wr_req_i)      req_q[sel]  <= wdata_i[SET_BIT];
      if (wr_mask_one_i) mask_q[sel] <= wdata_i[SET_BIT];
      if (wr_unmask_i)   mask_q      <= '0;
      if (wr_mask_all_i) mask_q      <= wdata_i[NUM_CH-1:0];
      tc_q <= (stat_rd_i ? '0 : tc_q) | tc_i;
    end
  end

  assign cmd_o    = cmd_q;
  assign mask_o   = mask_q;
  assign sw_req_o = req_q;
  assign status_o = {dreq_i | req_q, tc_q};

  a_r1_mclr_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> mask_o == '1 && cmd_o == '0 && sw_req_o == '0
            && status_o[NUM_CH-1:0] == '0);

  a_r10_tc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclr_i && !stat_rd_i |=>
      (status_o[NUM_CH-1:0] & $past(status_o[NUM_CH-1:0])) == $past(status_o[NUM_CH-1:0]));

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !mclr_i |=> status_o[NUM_CH-1:0] == $past(tc_i));

  a_r6_unmask_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unmask_i && !mclr_i |=> mask_o == '0);

  a_r5_one_mask_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_one_i && !mclr_i |=> $countones(mask_o ^ $past(mask_o)) <= 1);

endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_reg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [$clog2(NUM_CH)+1:0]         addr_i,
  input  logic [BYTE_W-1:0]                 wdata_i,
  input  logic                              wr_i,
  input  logic                              rd_i,
  output logic [BYTE_W-1:0]                 rdata_o,
  input  logic [NUM_CH*2*BYTE_W-1:0]        cur_addr_i,
  input  logic [NUM_CH*2*BYTE_W-1:0]        cur_cnt_i,
  input  logic [NUM_CH-1:0]                 tc_i,
  input  logic [NUM_CH-1:0]                 dreq_i,
  output logic [NUM_CH*2*BYTE_W-1:0]        base_addr_o,
  output logic [NUM_CH*2*BYTE_W-1:0]        base_cnt_o,
  output logic [NUM_CH*(BYTE_W-2)-1:0]      mode_o,
  output logic [NUM_CH-1:0]                 mask_o,
  output logic [BYTE_W-1:0]                 cmd_o,
  output logic [NUM_CH-1:0]                 sw_req_o
);

  localparam int REG_W  = 2 * BYTE_W;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = CH_W + 2;
  localparam int MODE_W = BYTE_W - 2;
  localparam int STAT_W = 2 * NUM_CH;

  logic                 rd_en, chan_port, is_cnt, ptr_hi, mclr, clr_ptr;
  logic [CH_W-1:0]      chan_sel;
  logic [STAT_W-1:0]    status;
  logic [REG_W-1:0]     cur_a [NUM_CH];
  logic [REG_W-1:0]     cur_c [NUM_CH];
  logic [REG_W-1:0]     rd_val;

  assign rd_en     = rd_i & ~wr_i;  // a write wins over a same-cycle read
  assign chan_port = (addr_i < ADDR_W'(2 * NUM_CH));
  assign chan_sel  = addr_i[CH_W:1];
  assign is_cnt    = addr_i[0];
  assign mclr      = wr_i && (addr_i == OFF_MCLR);
  assign clr_ptr   = (wr_i && (addr_i == OFF_CLR_PTR)) || mclr;

  dma_byte_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i ((wr_i | rd_i) & chan_port),
    .clear_i  (clr_ptr),
    .hi_o     (ptr_hi)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    chan_mode_t mode_n;

    dma_chan_regs #(.BYTE_W(BYTE_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_addr_i   (wr_i && chan_port && !is_cnt && chan_sel == CH_W'(n)),
      .wr_cnt_i    (wr_i && chan_port &&  is_cnt && chan_sel == CH_W'(n)),
      .wr_mode_i   (wr_i && addr_i == OFF_MODE && wdata_i[CH_W-1:0] == CH_W'(n)),
      .hi_i        (ptr_hi),
      .wdata_i     (wdata_i),
      .base_addr_o (base_addr_o[n*REG_W +: REG_W]),
      .base_cnt_o  (base_cnt_o[n*REG_W +: REG_W]),
      .mode_o      (mode_n)
    );

    assign mode_o[n*MODE_W +: MODE_W] = mode_n;
    assign cur_a[n] = cur_addr_i[n*REG_W +: REG_W];
    assign cur_c[n] = cur_cnt_i[n*REG_W +: REG_W];
  end

  dma_ctrl_regs #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wdata_i       (wdata_i),
    .wr_cmd_i      (wr_i && addr_i == OFF_CMD),
    .wr_req_i      (wr_i && addr_i == OFF_REQ),
    .wr_mask_one_i (wr_i && addr_i == OFF_MASK_ONE),
    .wr_unmask_i   (wr_i && addr_i == OFF_UNMASK),
    .wr_mask_all_i (wr_i && addr_i == OFF_MASK_ALL),
    .mclr_i        (mclr),
    .stat_rd_i     (rd_en && addr_i == OFF_CMD),
    .tc_i          (tc_i),
    .dreq_i        (dreq_i),
    .cmd_o         (cmd_o),
    .mask_o        (mask_o),
    .sw_req_o      (sw_req_o),
    .status_o      (status)
  );

  always_comb begin
    rd_val  = is_cnt ? cur_c[chan_sel] : cur_a[chan_sel];
    rdata_o = '0;
    if (rd_en) begin
      if (chan_port)               rdata_o = ptr_hi ? rd_val[REG_W-1:BYTE_W] : rd_val[BYTE_W-1:0];
      else if (addr_i == OFF_CMD)  rdata_o = status;
    end
  end

  a_r11_temp_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFF_MCLR |-> rdata_o == '0);

  a_r4_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  a_r11_mclr_keeps_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> $stable(base_addr_o) && $stable(base_cnt_o) && $stable(mode_o));

endmodule

// File: tb/dma_reg_port_tb.sv
module dma_reg_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [63:0] cur_addr_i, cur_cnt_i;
  logic [3:0]  tc_i = '0, dreq_i = '0;
  logic [63:0] base_addr_o, base_cnt_o;
  logic [23:0] mode_o;
  logic [3:0]  mask_o, sw_req_o;
  logic [7:0]  cmd_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_reg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .cur_addr_i(cur_addr_i), .cur_cnt_i(cur_cnt_i), .tc_i(tc_i), .dreq_i(dreq_i),
    .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o), .mode_o(mode_o),
    .mask_o(mask_o), .cmd_o(cmd_o), .sw_req_o(sw_req_o)
  );

  int    checks = 0, fails = 0;
  string tag = "R1";

  // behavioural model
  logic [15:0] m_ba [4], m_bc [4], cur_a [4], cur_c [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_req, m_tc;
  logic [7:0]  m_cmd;
  logic        m_ptr;

  always_comb begin
    for (int n = 0; n < 4; n++) begin
      cur_addr_i[n*16 +: 16] = cur_a[n];
      cur_cnt_i[n*16 +: 16]  = cur_c[n];
    end
  end

  task automatic model_reset();
    for (int n = 0; n < 4; n++) begin
      m_ba[n] = '0; m_bc[n] = '0; m_mode[n] = '0;
    end
    m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d,
                      input logic [3:0] tc = 4'h0, input logic [3:0] dq = 4'h0);
    logic [7:0]  exp_rd;
    logic [15:0] v;
    logic [63:0] eb, ec;
    logic [23:0] em;
    logic [3:0]  ntc;
    logic [1:0]  ch;
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d; tc_i = tc; dreq_i = dq;
    #1;
    exp_rd = '0;
    if (r && !w) begin
      if (a < 4'h8) begin
        v = a[0] ? cur_c[a[2:1]] : cur_a[a[2:1]];
        exp_rd = m_ptr ? v[15:8] : v[7:0];
      end else if (a == 4'h8) exp_rd = {dq | m_req, m_tc};
    end
    for (int n = 0; n < 4; n++) begin
      eb[n*16 +: 16] = m_ba[n];
      ec[n*16 +: 16] = m_bc[n];
      em[n*6 +: 6]   = m_mode[n];
    end
    chk("rdata", 64'(rdata_o), 64'(exp_rd));
    chk("mask", 64'(mask_o), 64'(m_mask));
    chk("cmd", 64'(cmd_o), 64'(m_cmd));
    chk("sw_req", 64'(sw_req_o), 64'(m_req));
    chk("base_addr", base_addr_o, eb);
    chk("base_cnt", base_cnt_o, ec);
    chk("mode", 64'(mode_o), 64'(em));
    if (rst_n) begin
      ntc = m_tc;
      if (r && !w && a == 4'h8) ntc = '0;
      ntc |= tc;
      if ((w || r) && a < 4'h8) begin
        ch = a[2:1];
        if (w) begin
          if (a[0]) begin
            if (m_ptr) m_bc[ch][15:8] = d; else m_bc[ch][7:0] = d;
          end else begin
            if (m_ptr) m_ba[ch][15:8] = d; else m_ba[ch][7:0] = d;
          end
        end
        m_ptr = ~m_ptr;
      end
      if (w) begin
        case (a)
          4'h8: m_cmd = d;
          4'h9: m_req[d[1:0]] = d[2];
          4'hA: m_mask[d[1:0]] = d[2];
          4'hB: m_mode[d[1:0]] = d[7:2];
          4'hC: m_ptr = 1'b0;
          4'hD: begin m_mask = 4'hF; m_ptr = 1'b0; m_cmd = '0; m_req = '0; ntc = '0; end
          4'hE: m_mask = '0;
          4'hF: m_mask = d[3:0];
          default: ;
        endcase
      end
      m_tc = ntc;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d); step(1, 0, a, d); endtask
  task automatic rd(input logic [3:0] a); step(0, 1, a, 8'h00); endtask
  task automatic idle(); step(0, 0, 4'h0, 8'h00); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int n = 0; n < 4; n++) begin
      cur_a[n] = 16'h1234 + 16'(n) * 16'h1111;
      cur_c[n] = 16'hF00D - 16'(n) * 16'h0101;
    end
    model_reset();

    // R1: reset state
    tag = "R1";
    repeat (3) idle();
    rst_n = 1'b1;
    idle();

    // R2: byte-wise loading through one port, shared pointer
    tag = "R2";
    wr(4'hC, 8'h00);
    wr(4'h0, 8'h34); wr(4'h0, 8'h12);
    wr(4'h1, 8'hFF); wr(4'h1, 8'h00);
    wr(4'h6, 8'hCD); wr(4'h6, 8'hAB);
    wr(4'h2, 8'h77);                 // ch1 addr low, pointer now high
    wr(4'h5, 8'h99);                 // lands in ch2 count high byte
    step(1, 1, 4'h7, 8'h5A);         // R2: write wins over read, rdata 0
    step(1, 1, 4'h7, 8'hA5);
    idle();

    // R3: clear pointer regardless of data
    tag = "R3";
    wr(4'h3, 8'h11);
    wr(4'hC, 8'hFF);
    wr(4'h3, 8'h22);                 // must be low byte again
    wr(4'hC, 8'h5A);
    wr(4'hC, 8'h00);                 // already low
    wr(4'h4, 8'h66);
    idle();

    // R4: reads of current address/count, pointer toggles on reads
    tag = "R4";
    wr(4'hC, 8'h00);
    for (int p = 0; p < 8; p++) begin
      rd(4'(p)); rd(4'(p));
    end
    cur_a[2] = 16'hBEEF; cur_c[1] = 16'h0102;
    rd(4'h4); wr(4'h4, 8'h3C); rd(4'h3); rd(4'h3);
    idle();

    // R5: single mask bit
    tag = "R5";
    wr(4'hA, 8'h00); wr(4'hA, 8'h02); wr(4'hA, 8'h04);
    wr(4'hA, 8'hF1); wr(4'hA, 8'h07); wr(4'hA, 8'h03);
    idle();

    // R6: all-mask load and clear-all
    tag = "R6";
    wr(4'hF, 8'h05); wr(4'hF, 8'hFA); wr(4'hE, 8'hC3);
    wr(4'hF, 8'h0F); wr(4'hE, 8'h00);
    idle();

    // R7: mode per channel
    tag = "R7";
    wr(4'hB, 8'h45); wr(4'hB, 8'h4A); wr(4'hB, 8'hC3);
    wr(4'hB, 8'h58); wr(4'hB, 8'h68);
    idle();

    // R8: command byte
    tag = "R8";
    wr(4'h8, 8'hA5); wr(4'h8, 8'h3C);
    idle();

    // R9: software requests
    tag = "R9";
    wr(4'h9, 8'h05); wr(4'h9, 8'h07); wr(4'h9, 8'h01);
    idle();

    // R10: status flags and request view
    tag = "R10";
    step(0, 0, 4'h0, 8'h00, 4'h2, 4'h0);
    step(0, 0, 4'h0, 8'h00, 4'h8, 4'h1);
    step(0, 1, 4'h8, 8'h00, 4'h0, 4'h4);   // returns tc 1010, then clears
    step(0, 1, 4'h8, 8'h00, 4'h1, 4'h0);   // reads 0, ch0 set same cycle
    step(0, 1, 4'h8, 8'h00, 4'h0, 4'h2);   // shows ch0 flag
    rd(4'h8);
    idle();

    // R11: master clear keeps base/mode, temp read returns zero
    tag = "R11";
    wr(4'h9, 8'h06); wr(4'h8, 8'h11); wr(4'hE, 8'h00);
    wr(4'h0, 8'h44);                         // pointer high
    step(0, 0, 4'h0, 8'h00, 4'h4, 4'h0);
    step(1, 0, 4'hD, 8'h00, 4'h2, 4'h0);     // clear wins over tc
    rd(4'h8);
    rd(4'hD);
    wr(4'h0, 8'h55);                         // pointer low after clear
    idle();

    summary();
    $finish;
  end

endmodule